// File: doc/BRIEF.md
# Interconnect Fabric Self-Test Sequencer

This controller runs one fixed, ordered self-test over a small reconfigurable processing array. A single start pulse launches six phases in turn. First comes a scan of the external memory window, then the master-controller register. Next, every route-through switch and then every local switch gets its own loop from shared memory and back. After that comes a scan of local memory, and last a run of preset vectors through the processing modules. The block drives plain address, data and switch-select lines towards models of those resources and compares what comes back.

Every mismatch becomes a one-byte fault record pushed into a 16-entry queue. The run never stops early: all elements are visited whatever fails. Switch faults are classed as minor and raise a sticky bypass flag so the fabric can route around them. When the last phase ends, `done_o` rises and `pass_o` tells whether any fault was seen.

Top module: `fabric_selftest`

## Requirements
- R1: After reset `phase_o`=0 and `busy_o`, `done_o`, `pass_o`, `flt_valid_o`, `ovf_o` and `bypass_o` are all 0.
- R2: `phase_o` codes are 1 external memory, 2 controller, 3 route-through switches, 4 local switches, 5 local memory, 6 modules, 7 done. During a run the code only ever steps up by one. The phases take 96, 6, 16, 8, 48 and 8 cycles.
- R3: The external scan (`mem_sel_o`=0, 16 words) makes three passes with the patterns 0x55, 0xAA and the address as data. Each pass writes every word and then reads every word back. A read mismatch logs phase 1, the address as index, and marks the fault major.
- R4: The controller test (`mem_sel_o`=1, address 0) uses the same three write-then-read patterns. A mismatch logs phase 2, index 0, major.
- R5: Each route-through switch i (`sw_bank_o`=0) gets two loop cycles, sending 0x55 and then 0xAA on `loop_tx_o` and expecting `loop_rx_i` to be equal. A failure in either cycle logs exactly one record: phase 3, index i, minor.
- R6: Each local switch uses the same loop with `sw_bank_o`=1 and logs phase 4 on failure.
- R7: The local memory (`mem_sel_o`=2, 8 words) is scanned as in R3 and logs phase 5.
- R8: For each module m, the block first writes the vector 0x99^m to local address m. In the next cycle it raises `mod_go_o` with `mod_sel_o`=m and expects `mod_res_i` = ~(0x99^m). A mismatch logs phase 6, index m, major.
- R9: A run never stops on a fault. `done_o` rises exactly 182 cycles after the edge that samples `start_i`. A start pulse seen while busy is ignored.
- R10: The record layout is {phase[2:0], minor, index[3:0]}. Records leave the queue oldest first. `flt_valid_o` shows the head, and `flt_pop_i` removes it.
- R11: A record that arrives while 16 are held is dropped and sets `ovf_o`. The flag stays set until the next accepted start.
- R12: `bypass_o` sets when a minor fault is logged and holds until the next accepted start.
- R13: In the done state `pass_o` is 1 only if no mismatch occurred during the run. An accepted start clears the queue and the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| busy_o | output | 1 | Test running |
| done_o | output | 1 | Test finished |
| pass_o | output | 1 | No fault seen in last run |
| phase_o | output | 3 | Current phase code |
| mem_sel_o | output | 2 | Memory target: 0 external, 1 controller, 2 local |
| mem_we_o | output | 1 | Write strobe |
| mem_addr_o | output | 4 | Word address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid in the same cycle |
| sw_en_o | output | 1 | Loop test active |
| sw_bank_o | output | 1 | 0 route-through, 1 local |
| sw_sel_o | output | 4 | Switch index |
| loop_tx_o | output | 8 | Data sent out of shared memory |
| loop_rx_i | input | 8 | Data returned by the loop |
| mod_go_o | output | 1 | Module run strobe |
| mod_sel_o | output | 4 | Module index |
| mod_res_i | input | 8 | Module result |
| flt_valid_o | output | 1 | Fault queue not empty |
| flt_data_o | output | 8 | Head fault record |
| flt_pop_i | input | 1 | Remove head record |
| ovf_o | output | 1 | Fault queue overflow |
| bypass_o | output | 1 | Minor fault present |

## Verification
The checks assume that `start_i` is a pulse and that `flt_pop_i` is raised only while `flt_valid_o` is high. They also assume the resource models answer combinationally in the same cycle as the address or loop data. The bench models the memories, loops and modules that way. It injects stuck bits, broken switches and bad modules only by changing model contents, so it never drives the design's own outputs out of contract. The queue is drained only after `done_o`, one pop per cycle, and only while a record is shown.

// File: rtl/fabric_selftest.sv
module fabric_selftest #(
  parameter int DW         = 8,
  parameter int EXT_AW     = 4,
  parameter int LOC_AW     = 3,
  parameter int N_RT       = 8,
  parameter int N_LS       = 4,
  parameter int N_MOD      = 4,
  parameter int FIFO_DEPTH = 16,
  parameter int IW         = (EXT_AW > LOC_AW) ? EXT_AW : LOC_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic [2:0]    phase_o,
  output logic [1:0]    mem_sel_o,
  output logic          mem_we_o,
  output logic [IW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          sw_en_o,
  output logic          sw_bank_o,
  output logic [IW-1:0] sw_sel_o,
  output logic [DW-1:0] loop_tx_o,
  input  logic [DW-1:0] loop_rx_i,
  output logic          mod_go_o,
  output logic [IW-1:0] mod_sel_o,
  input  logic [DW-1:0] mod_res_i,
  output logic          flt_valid_o,
  output logic [IW+3:0] flt_data_o,
  input  logic          flt_pop_i,
  output logic          ovf_o,
  output logic          bypass_o
);
  localparam logic [2:0] P_IDLE = 3'd0, P_EXT = 3'd1, P_CTL = 3'd2, P_RT = 3'd3,
                         P_LS = 3'd4, P_LOC = 3'd5, P_MOD = 3'd6, P_DONE = 3'd7;
  localparam logic [IW-1:0] EXT_LAST = IW'(2**EXT_AW - 1);
  localparam logic [IW-1:0] LOC_LAST = IW'(2**LOC_AW - 1);
  localparam logic [IW-1:0] RT_LAST  = IW'(N_RT - 1);
  localparam logic [IW-1:0] LS_LAST  = IW'(N_LS - 1);
  localparam logic [IW-1:0] MOD_LAST = IW'(N_MOD - 1);
  localparam logic [DW-1:0] PAT_A    = {(DW/2){2'b01}};
  localparam logic [DW-1:0] VEC_BASE = {(DW/4){4'b1001}};
  localparam int FPW = $clog2(FIFO_DEPTH);

  logic [2:0]    phase;
  logic [IW-1:0] idx, last;
  logic [1:0]    pat;
  logic          sub, loop_err;
  logic          fault_seen, ovf_q, byp_q;
  logic [IW+3:0] fifo_q [FIFO_DEPTH];
  logic [FPW-1:0] wp, rp;
  logic [FPW:0]   cnt;

  wire scan  = (phase == P_EXT) || (phase == P_CTL) || (phase == P_LOC);
  wire loopp = (phase == P_RT) || (phase == P_LS);
  wire modp  = (phase == P_MOD);
  wire busy  = scan || loopp || modp;
  wire go    = start_i && ((phase == P_IDLE) || (phase == P_DONE));

  wire [DW-1:0] idx_d    = DW'(idx);
  wire [DW-1:0] pat_d    = (pat == 2'd0) ? PAT_A : (pat == 2'd1) ? ~PAT_A : idx_d;
  wire [DW-1:0] vec      = VEC_BASE ^ idx_d;
  wire          loop_bad = loop_rx_i != loop_tx_o;
  wire          fail     = sub && ((scan && (mem_rdata_i != pat_d)) ||
                                   (loopp && (loop_bad || loop_err)) ||
                                   (modp && (mod_res_i != ~vec)));
  wire          full     = cnt == (FPW+1)'(FIFO_DEPTH);
  wire          push_ok  = fail && !full;
  wire          pop_ok   = flt_pop_i && (cnt != '0);

  always_comb begin
    case (phase)
      P_EXT:   last = EXT_LAST;
      P_RT:    last = RT_LAST;
      P_LS:    last = LS_LAST;
      P_LOC:   last = LOC_LAST;
      P_MOD:   last = MOD_LAST;
      default: last = '0;
    endcase
  end

  assign busy_o      = busy;
  assign done_o      = phase == P_DONE;
  assign pass_o      = done_o && !fault_seen;
  assign phase_o     = phase;
  assign mem_sel_o   = (phase == P_EXT) ? 2'd0 : (phase == P_CTL) ? 2'd1 : 2'd2;
  assign mem_we_o    = (scan || modp) && !sub;
  assign mem_addr_o  = idx;
  assign mem_wdata_o = modp ? vec : pat_d;
  assign sw_en_o     = loopp;
  assign sw_bank_o   = phase == P_LS;
  assign sw_sel_o    = idx;
  assign loop_tx_o   = sub ? ~PAT_A : PAT_A;
  assign mod_go_o    = modp && sub;
  assign mod_sel_o   = idx;
  assign flt_valid_o = cnt != '0;
  assign flt_data_o  = fifo_q[rp];
  assign ovf_o       = ovf_q;
  assign bypass_o    = byp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_IDLE; idx <= '0; pat <= '0; sub <= 1'b0; loop_err <= 1'b0;
    end else if (go) begin
      phase <= P_EXT; idx <= '0; pat <= '0; sub <= 1'b0; loop_err <= 1'b0;
    end else if (busy) begin
      loop_err <= loopp && !sub && loop_bad;
      if (scan) begin
        if (idx != last) idx <= idx + IW'(1);
        else begin
          idx <= '0;
          sub <= ~sub;
          if (sub) begin
            if (pat == 2'd2) begin pat <= '0; phase <= phase + 3'd1; end
            else pat <= pat + 2'd1;
          end
        end
      end else begin
        sub <= ~sub;
        if (sub) begin
          if (idx != last) idx <= idx + IW'(1);
          else begin idx <= '0; phase <= phase + 3'd1; end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; fault_seen <= 1'b0; ovf_q <= 1'b0; byp_q <= 1'b0;
    end else if (go) begin
      wp <= '0; rp <= '0; cnt <= '0; fault_seen <= 1'b0; ovf_q <= 1'b0; byp_q <= 1'b0;
    end else begin
      if (push_ok) wp <= wp + FPW'(1);
      if (pop_ok)  rp <= rp + FPW'(1);
      cnt <= cnt + (FPW+1)'(push_ok) - (FPW+1)'(pop_ok);
      if (fail) fault_seen <= 1'b1;
      if (fail && full) ovf_q <= 1'b1;
      if (fail && loopp) byp_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) fifo_q[wp] <= {phase, loopp, idx};
  end
endmodule

// File: rtl/fabric_selftest_chk.sv
module fabric_selftest_chk #(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          pass_o,
  input logic [2:0]    phase_o,
  input logic [1:0]    mem_sel_o,
  input logic          mem_we_o,
  input logic [IW-1:0] mem_addr_o,
  input logic          sw_en_o,
  input logic          sw_bank_o,
  input logic          mod_go_o,
  input logic [IW-1:0] mod_sel_o,
  input logic          flt_valid_o,
  input logic          flt_pop_i,
  input logic          ovf_o,
  input logic          bypass_o
);
  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && (phase_o != $past(phase_o))) |-> (phase_o == $past(phase_o) + 3'd1));
  assert_we_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (busy_o && !sw_en_o && !mod_go_o));
  assert_bank_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en_o |-> ((phase_o == 3'd3 && !sw_bank_o) || (phase_o == 3'd4 && sw_bank_o)));
  assert_load_before_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mod_go_o |-> ($past(mem_we_o) && ($past(mem_addr_o) == mod_sel_o) && (mem_sel_o == 2'd2)));
  assert_queue_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid_o && !flt_pop_i && !start_i) |=> flt_valid_o);
  assert_no_overflow_loss_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !start_i) |=> ovf_o);
  assert_bypass_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_o && !start_i) |=> bypass_o);
  assert_done_not_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  assert_pass_only_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> done_o);
endmodule

bind fabric_selftest fabric_selftest_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .pass_o(pass_o), .phase_o(phase_o), .mem_sel_o(mem_sel_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .sw_en_o(sw_en_o), .sw_bank_o(sw_bank_o),
  .mod_go_o(mod_go_o), .mod_sel_o(mod_sel_o), .flt_valid_o(flt_valid_o),
  .flt_pop_i(flt_pop_i), .ovf_o(ovf_o), .bypass_o(bypass_o)
);

// File: tb/test_fabric_selftest.sv
`timescale 1ns/1ps
module test_fabric_selftest;
  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, flt_pop_i = 1'b0;
  logic busy_o, done_o, pass_o, mem_we_o, sw_en_o, sw_bank_o, mod_go_o;
  logic flt_valid_o, ovf_o, bypass_o;
  logic [2:0] phase_o;
  logic [1:0] mem_sel_o;
  logic [3:0] mem_addr_o, sw_sel_o, mod_sel_o;
  logic [7:0] mem_wdata_o, mem_rdata_i, loop_tx_o, loop_rx_i, mod_res_i, flt_data_o;

  fabric_selftest i_fabric_selftest (.*);

  always #4 clk = ~clk;

  logic [7:0] ext_m [16];
  logic [7:0] loc_m [8];
  logic [7:0] ctl_r;
  logic       ext_flt_en = 0, ext_inv = 0, ctl_flt = 0, loc_flt_en = 0;
  logic [3:0] ext_flt_a = 0;
  logic [2:0] loc_flt_a = 0;
  logic [7:0] rt_bad = 0;
  logic [3:0] ls_bad = 0, mod_bad = 0;

  always_comb begin
    case (mem_sel_o)
      2'd0: begin
        mem_rdata_i = ext_m[mem_addr_o];
        if (ext_flt_en && mem_addr_o == ext_flt_a) mem_rdata_i[0] = 1'b1;
        if (ext_inv) mem_rdata_i = ~mem_rdata_i;
      end
      2'd1: begin
        mem_rdata_i = ctl_r;
        if (ctl_flt) mem_rdata_i[7] = 1'b0;
      end
      default: begin
        mem_rdata_i = loc_m[mem_addr_o[2:0]];
        if (loc_flt_en && mem_addr_o[2:0] == loc_flt_a) mem_rdata_i[1] = 1'b0;
      end
    endcase
    loop_rx_i = loop_tx_o ^ ((sw_en_o && (sw_bank_o ? ls_bad[sw_sel_o[1:0]] : rt_bad[sw_sel_o[2:0]])) ? 8'h01 : 8'h00);
    mod_res_i = ~loc_m[mod_sel_o[2:0]] ^ (mod_bad[mod_sel_o[1:0]] ? 8'h10 : 8'h00);
  end

  always @(posedge clk) if (mem_we_o) begin
    case (mem_sel_o)
      2'd0: ext_m[mem_addr_o] <= mem_wdata_o;
      2'd1: ctl_r <= mem_wdata_o;
      default: loc_m[mem_addr_o[2:0]] <= mem_wdata_o;
    endcase
  end

  int errors = 0, checks = 0, cyc = 0;
  int ph_cnt [8];
  logic [2:0] last_ph;
  logic order_bad;
  logic [7:0] got [32];
  int n_got;

  always @(posedge clk) if (busy_o) begin
    ph_cnt[phase_o] <= ph_cnt[phase_o] + 1;
    if (phase_o != last_ph) begin
      if (phase_o != last_ph + 3'd1) order_bad <= 1'b1;
      last_ph <= phase_o;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_seq(input int poke, output int n);
    for (int i = 0; i < 8; i++) ph_cnt[i] = 0;
    last_ph = 3'd0; order_bad = 1'b0;
    @(negedge clk) start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    n = 0;
    forever begin
      @(posedge clk); n++; #1;
      start_i = (n == poke);
      if (done_o || n > 1000) break;
    end
    start_i = 1'b0;
  endtask

  task automatic drain();
    n_got = 0;
    while (flt_valid_o && n_got < 32) begin
      @(negedge clk);
      got[n_got] = flt_data_o; n_got++;
      flt_pop_i = 1'b1;
      @(posedge clk); #1 flt_pop_i = 1'b0;
    end
  endtask

  task automatic clear_faults();
    ext_flt_en = 0; ext_inv = 0; ctl_flt = 0; loc_flt_en = 0;
    rt_bad = 0; ls_bad = 0; mod_bad = 0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 phase", phase_o, 0); chk("R1 busy", busy_o, 0); chk("R1 done", done_o, 0);
    chk("R1 pass", pass_o, 0); chk("R1 valid", flt_valid_o, 0);
    chk("R1 ovf", ovf_o, 0); chk("R1 bypass", bypass_o, 0);
  endtask

  task automatic t_clean();
    int n;
    clear_faults();
    run_seq(-1, n);
    chk("R9 cycles to done", n, 182);
    chk("R13 pass clean", pass_o, 1);
    chk("R2 order", order_bad, 0);
    chk("R3 ext cycles", ph_cnt[1], 96);
    chk("R4 ctl cycles", ph_cnt[2], 6);
    chk("R5 rt cycles", ph_cnt[3], 16);
    chk("R6 ls cycles", ph_cnt[4], 8);
    chk("R7 loc cycles", ph_cnt[5], 48);
    chk("R8 mod cycles", ph_cnt[6], 8);
    chk("R10 empty", flt_valid_o, 0);
    chk("R12 no bypass", bypass_o, 0);
    chk("R11 ovf cleared", ovf_o, 0);
  endtask

  task automatic t_ext_fault();
    int n;
    clear_faults(); ext_flt_en = 1; ext_flt_a = 4'd5;
    run_seq(-1, n);
    chk("R13 pass low", pass_o, 0);
    drain();
    chk("R3 record count", n_got, 1);
    chk("R3 record", got[0], 8'h25);
    chk("R12 no bypass major", bypass_o, 0);
  endtask

  task automatic t_switch();
    int n;
    clear_faults(); rt_bad[3] = 1; ls_bad[2] = 1;
    run_seq(-1, n);
    chk("R9 done count", n, 182);
    chk("R12 bypass", bypass_o, 1);
    drain();
    chk("R5 R6 count", n_got, 2);
    chk("R5 record", got[0], 8'h73);
    chk("R6 record", got[1], 8'h92);
  endtask

  task automatic t_ctl_mod();
    int n;
    clear_faults(); ctl_flt = 1; mod_bad[1] = 1;
    run_seq(-1, n);
    drain();
    chk("R4 R8 count", n_got, 2);
    chk("R4 record", got[0], 8'h40);
    chk("R8 record", got[1], 8'hC1);
    chk("R12 major no bypass", bypass_o, 0);
  endtask

  task automatic t_loc();
    int n;
    clear_faults(); loc_flt_en = 1; loc_flt_a = 3'd6;
    run_seq(-1, n);
    drain();
    chk("R7 count", n_got, 2);
    chk("R7 record a", got[0], 8'hA6);
    chk("R7 record b", got[1], 8'hA6);
  endtask

  task automatic t_ovf();
    int n;
    clear_faults(); ext_inv = 1;
    run_seq(-1, n);
    chk("R9 no early stop", n, 182);
    chk("R11 ovf set", ovf_o, 1);
    drain();
    chk("R11 kept 16", n_got, 16);
    chk("R10 oldest first", got[0], 8'h20);
    chk("R10 second", got[1], 8'h21);
    chk("R10 drained", flt_valid_o, 0);
  endtask

  task automatic t_restart_ignored();
    int n;
    clear_faults();
    run_seq(50, n);
    chk("R9 start while busy ignored", n, 182);
    chk("R13 pass after restart attempt", pass_o, 1);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL R9 watchdog actual=%0d expected<150000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_clean();
    t_ext_fault();
    t_switch();
    t_ctl_mod();
    t_loc();
    t_ovf();
    t_clean();
    t_restart_ignored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule